// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches a single 16-bit word from a three-wire serial EEPROM. A one-cycle `start` pulse, together with a word address, begins an access. The controller raises chip select and sends a read command as a fixed opcode followed by the address. After a short quiet interval on the data-in line it clocks in sixteen data bits. It then releases the device and issues one closing clock pulse. A one-cycle `done` strobe presents the fetched word.

All serial timing comes from the system clock. Two intervals are configured in nanoseconds: the data setup/hold interval and the clock-level stable interval. They are converted at elaboration into cycle counts rounded up, with a floor of one cycle. The block can therefore be retargeted to any clock frequency without touching the logic. The data-out line from the device passes through a two-flop synchronizer before it is sampled.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, and whenever no access is in progress, `eeCs`, `eeSk`, `eeDi` and `done` are all low.
- R2: During an access, `eeCs` rises exactly once, before the first rising `eeSk`. It stays high through the command and data phases and falls exactly once, after the last data clock.
- R3: The command is sent on the rising `eeSk` edges that occur while `eeCs` is high. The opcode comes first (OP_W bits, default 3'b110), then the ADDR_W address bits. Both fields are sent MSB first. An access has exactly OP_W+ADDR_W+DATA_W rising edges with `eeCs` high.
- R4: Before every rising `eeSk` with `eeCs` high, `eeDi` has held its value for at least SETUP_CYC cycles. `eeDi` does not change while `eeSk` is high.
- R5: Every high level of `eeSk` lasts exactly STABLE_CYC cycles. Between two rising edges of one access, the low level lasts at least STABLE_CYC cycles. The cycle counts are ceil(CLK_HZ·ns/1e9), with a minimum of 1.
- R6: Once the last command bit has been clocked, `eeDi` is low during every later high phase of `eeSk` in the access. `eeDi` is never high while `eeCs` is low.
- R7: DATA_W (16) bits are read MSB first, each sampled while `eeSk` is high. The returned `rdData` equals the device word at the requested address.
- R8: At the end of an access, `eeCs` and `eeDi` go low. Exactly one full `eeSk` pulse is then issued with `eeCs` low, and only after that pulse does `done` assert.
- R9: `done` is high for exactly one cycle with `rdData` valid. `rdData` holds its value until the next access completes.
- R10: A `start` pulse that arrives while an access is in progress is ignored. No second access follows, and the in-flight result is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a word read |
| addr | input | ADDR_W | Word address, captured with `start` |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data toward the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM (asynchronous) |
| rdData | output | DATA_W | Word returned by the last completed access |
| done | output | 1 | One-cycle completion strobe |

## Verification
The property checks assume that `eeDo` changes only near a rising serial clock. They also assume that `start` is a single-cycle pulse, with the address held on the same cycle. The bench's device model meets both assumptions. It updates its output bit on each rising `eeSk` while selected and returns a word computed from the received address. This leaves a full stable interval before the controller samples through its synchronizer. The stimulus sweeps every address under the default address width. On a subset of those accesses it injects a stray `start` in mid-transfer.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  // Control phases of one word read.
  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,   // command bit presented, clock low
    S_CMDHI,   // command clock high
    S_CMDLO,   // command clock low
    S_HOLD,    // data-in forced low after the command
    S_RDHI,    // data clock high, sample at its end
    S_RDLO,    // data clock low
    S_QUIET,   // chip select released
    S_TAILHI,  // closing clock high with chip select low
    S_TAILLO   // closing clock low
  } eerdState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;       // capture opcode+address into the command shifter
    logic shiftCmd;   // advance to the next command bit
    logic sample;     // shift the synchronized data-out bit in
    logic finish;     // publish the word and pulse done
    logic csLvl;      // chip select level for the next cycle
    logic skLvl;      // serial clock level for the next cycle
    logic diFromCmd;  // data-in follows the command MSB (else low)
  } eerdStrobe_t;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int nsToCycles(longint unsigned hz, longint unsigned ns);
    longint unsigned raw;
    raw = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (raw < 64'd1) ? 1 : int'(raw);
  endfunction

endpackage

// File: rtl/eerd_ctrl.sv
module eerd_ctrl
  import eerd_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned SETUP_NS  = 400,
  parameter int unsigned STABLE_NS = 9000,
  parameter int unsigned CMD_W     = 9,
  parameter int unsigned DATA_W    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output eerdStrobe_t strobe
);

  localparam int SETUP_CYC  = nsToCycles(CLK_HZ, SETUP_NS);
  localparam int STABLE_CYC = nsToCycles(CLK_HZ, STABLE_NS);
  localparam int TMAX       = (SETUP_CYC > STABLE_CYC) ? SETUP_CYC : STABLE_CYC;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int MAXB       = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CW         = $clog2(MAXB + 1);
  localparam logic [TW-1:0] SETUP_LD  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] STABLE_LD = TW'(STABLE_CYC - 1);
  localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_W - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);

  eerdState_t      state, nextState;
  logic [TW-1:0]   timer;
  logic [CW-1:0]   bitCnt;
  logic            expire;

  assign expire = (timer == '0);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = S_SETUP;
        end
      end
      S_SETUP: begin
        strobe.csLvl     = 1'b1;
        strobe.diFromCmd = 1'b1;
        if (expire) nextState = S_CMDHI;
      end
      S_CMDHI: begin
        strobe.csLvl     = 1'b1;
        strobe.skLvl     = 1'b1;
        strobe.diFromCmd = 1'b1;
        if (expire) nextState = S_CMDLO;
      end
      S_CMDLO: begin
        strobe.csLvl     = 1'b1;
        strobe.diFromCmd = 1'b1;
        if (expire) begin
          if (bitCnt == CMD_LAST) begin
            nextState = S_HOLD;
          end else begin
            strobe.shiftCmd = 1'b1;
            nextState       = S_SETUP;
          end
        end
      end
      S_HOLD: begin
        strobe.csLvl = 1'b1;
        if (expire) nextState = S_RDHI;
      end
      S_RDHI: begin
        strobe.csLvl = 1'b1;
        strobe.skLvl = 1'b1;
        if (expire) begin
          strobe.sample = 1'b1;
          nextState     = S_RDLO;
        end
      end
      S_RDLO: begin
        strobe.csLvl = 1'b1;
        if (expire) nextState = (bitCnt == DATA_LAST) ? S_QUIET : S_RDHI;
      end
      S_QUIET: begin
        if (expire) nextState = S_TAILHI;
      end
      S_TAILHI: begin
        strobe.skLvl = 1'b1;
        if (expire) nextState = S_TAILLO;
      end
      S_TAILLO: begin
        if (expire) begin
          strobe.finish = 1'b1;
          nextState     = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      timer  <= '0;
      bitCnt <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        timer <= (nextState == S_SETUP || nextState == S_HOLD) ? SETUP_LD : STABLE_LD;
      end else if (!expire) begin
        timer <= timer - 1'b1;
      end
      if (strobe.load) begin
        bitCnt <= '0;
      end else if ((state == S_CMDLO || state == S_RDLO) && expire) begin
        bitCnt <= (nextState == S_HOLD || nextState == S_QUIET) ? '0 : bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/eerd_dpath.sv
module eerd_dpath
  import eerd_pkg::*;
#(
  parameter int unsigned OP_W   = 3,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter logic [OP_W-1:0] OPCODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  eerdStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              eeDo,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  localparam int CMD_W = OP_W + ADDR_W;

  logic [CMD_W-1:0]  cmdSr;
  logic [DATA_W-1:0] acc;
  logic [1:0]        doSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      eeCs   <= 1'b0;
      eeSk   <= 1'b0;
      eeDi   <= 1'b0;
      done   <= 1'b0;
      cmdSr  <= '0;
      acc    <= '0;
      rdData <= '0;
      doSync <= '0;
    end else begin
      doSync <= {doSync[0], eeDo};
      eeCs   <= strobe.csLvl;
      eeSk   <= strobe.skLvl;
      eeDi   <= strobe.diFromCmd ? cmdSr[CMD_W-1] : 1'b0;
      done   <= strobe.finish;
      if (strobe.load) begin
        cmdSr <= {OPCODE, addr};
      end else if (strobe.shiftCmd) begin
        cmdSr <= {cmdSr[CMD_W-2:0], 1'b0};
      end
      if (strobe.sample) begin
        acc <= {acc[DATA_W-2:0], doSync[1]};
      end
      if (strobe.finish) begin
        rdData <= acc;
      end
    end
  end

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eerd_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned SETUP_NS  = 400,
  parameter int unsigned STABLE_NS = 9000,
  parameter int unsigned OP_W      = 3,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 16,
  parameter logic [OP_W-1:0] OPCODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  input  logic              eeDo,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  localparam int unsigned CMD_W = OP_W + ADDR_W;

  eerdStrobe_t strobe;

  eerd_ctrl #(
    .CLK_HZ(CLK_HZ), .SETUP_NS(SETUP_NS), .STABLE_NS(STABLE_NS),
    .CMD_W(CMD_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .strobe(strobe)
  );

  eerd_dpath #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPCODE(OPCODE)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .addr(addr), .eeDo(eeDo),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .rdData(rdData), .done(done)
  );

endmodule

// File: rtl/eerd_checker.sv
module eerd_checker
  import eerd_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned STABLE_NS = 9000
) (
  input logic clk,
  input logic rst,
  input logic eeCs,
  input logic eeSk,
  input logic eeDi,
  input logic done
);

  localparam int STABLE_CYC = nsToCycles(CLK_HZ, STABLE_NS);

  int unsigned hiCnt;

  always_ff @(posedge clk) begin
    if (rst) hiCnt <= 0;
    else if (eeSk) hiCnt <= hiCnt + 1;
    else hiCnt <= 0;
  end

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_release: assert property (@(posedge clk) disable iff (rst)
    done |-> (!eeCs && !eeSk && !eeDi));

  a_r6_di_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !eeCs |-> !eeDi);

  a_r2_cs_steady_while_sk_high: assert property (@(posedge clk) disable iff (rst)
    eeSk |-> $stable(eeCs));

  a_r4_di_steady_while_sk_high: assert property (@(posedge clk) disable iff (rst)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));

  a_r5_sk_high_width: assert property (@(posedge clk) disable iff (rst)
    $fell(eeSk) |-> (hiCnt >= STABLE_CYC));

endmodule

bind eeprom_word_reader eerd_checker #(
  .CLK_HZ(CLK_HZ), .STABLE_NS(STABLE_NS)
) u_eerdChk (
  .clk(clk), .rst(rst), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .done(done)
);

// File: tb/test_eeprom_word_reader.sv
module test_eeprom_word_reader;

  localparam int OP_W      = 3;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 16;
  localparam int CMD_W     = OP_W + ADDR_W;
  localparam int SETUP_NS  = 40;
  localparam int STABLE_NS = 200;
  // 125 MHz: cycles = ceil(125 * ns / 1000)
  localparam int SETUP_EXP  = (125 * SETUP_NS + 999) / 1000;   // 5
  localparam int STABLE_EXP = (125 * STABLE_NS + 999) / 1000;  // 25

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              eeCs, eeSk, eeDi;
  logic              eeDo = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              done;

  always #4 clk = ~clk;

  eeprom_word_reader #(
    .CLK_HZ(125_000_000), .SETUP_NS(SETUP_NS), .STABLE_NS(STABLE_NS),
    .OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPCODE(3'b110)
  ) i_eeprom_word_reader (
    .clk(clk), .rst(rst), .start(start), .addr(addr),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo),
    .rdData(rdData), .done(done)
  );

  int tests = 0;
  int fails = 0;

  function automatic logic [DATA_W-1:0] wordOf(int a);
    return DATA_W'((a * 40253) ^ 16'hC35A);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Device model: captures the command, then drives data bits MSB first.
  logic [CMD_W-1:0] cmdRx = '0;
  int rxCnt = 0;
  always @(posedge eeSk or negedge eeCs) begin
    if (!eeCs) begin
      rxCnt = 0;
      eeDo  = 1'b0;
    end else begin
      rxCnt++;
      if (rxCnt <= CMD_W) begin
        cmdRx = {cmdRx[CMD_W-2:0], eeDi};
      end else if (rxCnt - CMD_W - 1 < DATA_W) begin
        eeDo = wordOf(int'(cmdRx[ADDR_W-1:0]))[DATA_W - 1 - (rxCnt - CMD_W - 1)];
      end
    end
  end

  // Protocol monitor, cumulative counters sampled at the falling clock edge.
  int cyc = 0;
  int diAge = 0, skAge = 0, accRise = 0;
  int errSetup = 0, errHigh = 0, errLow = 0, errDi = 0;
  int csRiseSk = 0, tailRises = 0, csRises = 0, csFalls = 0, doneCnt = 0;
  logic prevDi = 1'b0, prevSk = 1'b0, prevCs = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (eeDi == prevDi) diAge++; else diAge = 1;
    if (eeCs && !prevCs) begin csRises++; accRise = 0; end
    if (!eeCs && prevCs) csFalls++;
    if (eeSk == prevSk) skAge++;
    else begin
      if (eeSk) begin
        if (eeCs) begin
          if (diAge - 1 < SETUP_EXP) errSetup++;
          if (accRise > 0 && skAge < STABLE_EXP) errLow++;
          accRise++;
          csRiseSk++;
        end else begin
          tailRises++;
        end
      end else if (skAge != STABLE_EXP) begin
        errHigh++;
      end
      skAge = 1;
    end
    if (eeCs && eeSk && accRise > CMD_W && eeDi) errDi++;
    if (!eeCs && eeDi) errDi++;
    if (done) doneCnt++;
    prevDi = eeDi;
    prevSk = eeSk;
    prevCs = eeCs;
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Watchdog: a hung run counts as a failed check.
  always @(negedge clk) begin
    if (cyc > 195_000) begin
      chk(1'b0, "WD", "watchdog cycle count", cyc, 195_000);
      finishRun();
    end
  end

  task automatic doRead(input int a, input bit poke);
    int sSetup, sHigh, sLow, sDi, sRiseSk, sTail, sCsR, sCsF, sDone, w;
    logic [DATA_W-1:0] got;
    sSetup = errSetup; sHigh = errHigh; sLow = errLow; sDi = errDi;
    sRiseSk = csRiseSk; sTail = tailRises; sCsR = csRises; sCsF = csFalls;
    sDone = doneCnt;
    @(negedge clk);
    start = 1'b1;
    addr  = ADDR_W'(a);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      addr  = ADDR_W'(a ^ 42);
      @(negedge clk);
      start = 1'b0;
      addr  = ADDR_W'(a);
    end
    w = 0;
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, "R9", "done seen", done, 1);
    got = rdData;
    chk(got == wordOf(a), "R7", "word read", got, wordOf(a));
    chk(cmdRx == {3'b110, ADDR_W'(a)}, "R3", "command received", cmdRx, {3'b110, ADDR_W'(a)});
    chk(csRiseSk - sRiseSk == CMD_W + DATA_W, "R3", "clock rises with cs high",
        csRiseSk - sRiseSk, CMD_W + DATA_W);
    chk(csRises - sCsR == 1 && csFalls - sCsF == 1, "R2", "cs rise/fall count",
        (csRises - sCsR) * 16 + (csFalls - sCsF), 17);
    chk(errSetup == sSetup, "R4", "setup violations", errSetup - sSetup, 0);
    chk(errHigh == sHigh && errLow == sLow, "R5", "clock level width violations",
        (errHigh - sHigh) + (errLow - sLow), 0);
    chk(errDi == sDi, "R6", "data-in high in data phase or deselected", errDi - sDi, 0);
    chk(tailRises - sTail == 1 && !eeCs, "R8", "closing pulse before done",
        tailRises - sTail, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(rdData == got, "R9", "rdData holds", rdData, got);
    chk(doneCnt - sDone == 1, "R9", "single done per access", doneCnt - sDone, 1);
    if (poke) begin
      repeat (200) @(negedge clk);
      chk(csRises - sCsR == 1 && doneCnt - sDone == 1 && !eeCs, "R10",
          "stray start ignored", (csRises - sCsR) * 16 + (doneCnt - sDone), 17);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(eeCs == 1'b0, "R1", "cs in reset", eeCs, 0);
    chk(eeSk == 1'b0, "R1", "sk in reset", eeSk, 0);
    chk(eeDi == 1'b0, "R1", "di in reset", eeDi, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(!eeCs && !eeSk && !eeDi && !done && csRises == 0, "R1", "idle lines",
        {eeCs, eeSk, eeDi, done}, 0);
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      doRead(a, (a % 16) == 5);
    end
    doRead(0, 1'b0);
    doRead((1 << ADDR_W) - 1, 1'b0);
    repeat (20) @(negedge clk);
    chk(!eeCs && !eeSk && !eeDi && !done, "R1", "idle after accesses",
        {eeCs, eeSk, eeDi, done}, 0);
    finishRun();
  end

endmodule